// File: doc/BRIEF.md
# External Bus Release Arbiter

This block sits on the bus-master side of a shared external memory bus. It lends the whole bus to an outside device and takes it back afterwards. The outside device asks for the bus by pulling an active-low request line low. The block answers on an active-low acknowledge line once it has floated its drivers. All timing is kept at half-cycle resolution of the bus clock. Internally this uses one fast clock and a phase register: each edge of the fast clock is one half bus cycle, and the block drives the bus clock out itself. A clock edge where `bus_ck_o` goes from 0 to 1 is a rising bus edge, and one where it goes from 1 to 0 is a falling bus edge.

There are three groups of drivers, each with its own output enable. The first is address/data. The second is the control strobes, which can also be forced to their inactive level. The third is the SDRAM pins: clock-enable and the row and column strobes. A park option keeps the SDRAM pins driven while the bus is lent out, holding the last values they had while the block owned the bus. If a memory refresh is waiting while the bus is away, an active-low refresh-request output asks the outside device to hand the bus back. The memory cycle engine and the refresh timer are outside this block. They appear only as a `busy_i` level, a `rfsh_req_i` level and the `grant_o` output, which says when new internal cycles may start.

Top module: `xbus_release`

## Requirements
- R1: `breq_n_i` is sampled only at falling bus edges. A low level that spans only a rising bus edge has no effect.
- R2: At the rising bus edge after a falling edge that sampled `breq_n_i` low, the release starts if `busy_i` and `rfsh_req_i` are both low at that edge. At this edge `grant_o` drops to 0 and `ctl_idle_o` goes to 1. All groups stay driven.
- R3: One bus cycle later, at the next rising edge, `ad_oe_o` and `ctl_oe_o` go to 0. `sd_oe_o` goes to 0 unless `park_en_i` is 1.
- R4: `back_n_o` goes low at the falling edge half a cycle after the tristate edge of R3.
- R5: After a falling edge samples `breq_n_i` high while the bus is lent, the block acts 1.5 cycles later, at a rising edge. There `ctl_oe_o` and `sd_oe_o` go to 1, with `ctl_idle_o` still 1.
- R6: `back_n_o` returns high at the next falling edge.
- R7: At the next rising edge, `ad_oe_o` and `grant_o` return to 1 and `ctl_idle_o` returns to 0.
- R8: No release starts while `busy_i` or `rfsh_req_i` is high at the deciding rising edge. The bus stays owned and `grant_o` stays 1.
- R9: `rfsh_n_o` is low exactly while `rfsh_req_i` is 1 and `back_n_o` is 0.
- R10: When `park_en_i` is 1, `sd_oe_o` stays 1 throughout the release. `sd_out_o` then holds the `sd_in_i` value captured at the last edge at which the bus was owned. While the bus is owned, `sd_out_o` equals `sd_in_i`.
- R11: `ad_oe_o` is never 1 while `back_n_o` is 0. `ctl_oe_o` is 1 while `back_n_o` is 0 only with `ctl_idle_o` at 1.
- R12: After synchronous reset the bus is owned: `grant_o`, `ad_oe_o`, `ctl_oe_o` and `sd_oe_o` are 1, `back_n_o` is 1, `ctl_idle_o` is 0 and `bus_ck_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two edges per bus cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| breq_n_i | input | 1 | External bus request, active low |
| busy_i | input | 1 | Internal bus cycle in progress |
| rfsh_req_i | input | 1 | Memory refresh pending |
| park_en_i | input | 1 | Keep the SDRAM pins driven during release |
| sd_in_i | input | SD_W | SDRAM pin values from the cycle engine |
| bus_ck_o | output | 1 | Bus clock |
| grant_o | output | 1 | Internal cycles may start |
| ad_oe_o | output | 1 | Address/data output enable |
| ctl_oe_o | output | 1 | Control strobe output enable |
| ctl_idle_o | output | 1 | Force control strobes to their inactive level |
| sd_oe_o | output | 1 | SDRAM pin output enable |
| sd_out_o | output | SD_W | SDRAM pin values to the pads |
| back_n_o | output | 1 | Bus acknowledge, active low |
| rfsh_n_o | output | 1 | Refresh wants the bus back, active low |

## Verification
The bench sends a request pulse so short that it covers only a rising bus edge. A design that samples on the wrong edge would start a release there. It raises the request while `busy_i` or a refresh is pending, and a design that ignored either would float the bus under an active cycle. It withdraws the request at different half-cycle phases, so a wrong 1.5-cycle count would shift the strobe, acknowledge or address/data return edges by half a cycle. It also changes `sd_in_i` while the bus is parked, and a design that let the live values through would show them on `sd_out_o`.

// File: rtl/xbr_pkg.sv
// Shared types for the external bus release arbiter.
package xbr_pkg;
    // Hand-off sequence states; each state lasts a whole number of half cycles.
    typedef enum logic [2:0] {
        ST_OWN,   // bus owned, normal cycles allowed
        ST_PREP,  // strobes forced inactive, groups still driven
        ST_HIZ,   // groups floated, acknowledge not yet given
        ST_LENT,  // bus lent out
        ST_WAIT,  // request withdrawn, counting down to reclaim
        ST_RECL,  // control and SDRAM driven inactive again
        ST_BACKH  // acknowledge withdrawn, address/data next
    } xbr_state_t;
endpackage

// File: rtl/xbr_phase.sv
// Bus clock phase generator and request sampler.
// Each clk edge is one half bus cycle; ph_q=0 before an edge marks a rising
// bus edge. The request is sampled only at falling bus edges.
// Assumes breq_n is already synchronous to clk.
module xbr_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic breq_n,
    output logic rise_o,
    output logic bus_ck_o,
    output logic req_o
);
    logic ph_q;
    logic req_q;

    // Toggle the phase and capture the request on falling bus edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= 1'b0;
            req_q <= 1'b0;
        end else begin
            ph_q <= ~ph_q;
            if (ph_q) req_q <= ~breq_n;
        end
    end

    assign rise_o   = ~ph_q;
    assign bus_ck_o = ph_q;
    assign req_o    = req_q;

    AST_REQ_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(req_q) |-> $past(ph_q)); // R1
endmodule

// File: rtl/xbr_seq.sv
// Hand-off sequencer: walks the release and reclaim steps on the required
// half-cycle edges and decodes the output enables per state.
// Assumes rise marks rising bus edges and req is the sampled request level.
module xbr_seq
    import xbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic req,
    input  logic busy,
    input  logic rfsh,
    input  logic park,
    output logic grant,
    output logic ad_oe,
    output logic ctl_oe,
    output logic ctl_idle,
    output logic sd_oe,
    output logic back_n
);
    xbr_state_t st_q, st_d;

    // Next-state choice: every step is tied to one edge type.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_OWN:   if (rise && req && !busy && !rfsh) st_d = ST_PREP;
            ST_PREP:  if (rise)        st_d = ST_HIZ;
            ST_HIZ:   if (!rise)       st_d = ST_LENT;
            ST_LENT:  if (rise && !req) st_d = ST_WAIT;
            ST_WAIT:  if (rise)        st_d = ST_RECL;
            ST_RECL:  if (!rise)       st_d = ST_BACKH;
            ST_BACKH: if (rise)        st_d = ST_OWN;
            default:                   st_d = ST_OWN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OWN;
        else        st_q <= st_d;
    end

    // Output decode per state.
    always_comb begin
        grant    = 1'b0;
        ad_oe    = 1'b0;
        ctl_oe   = 1'b0;
        ctl_idle = 1'b1;
        sd_oe    = park;
        back_n   = 1'b1;
        case (st_q)
            ST_OWN: begin
                grant = 1'b1; ad_oe = 1'b1; ctl_oe = 1'b1;
                ctl_idle = 1'b0; sd_oe = 1'b1;
            end
            ST_PREP: begin
                ad_oe = 1'b1; ctl_oe = 1'b1; sd_oe = 1'b1;
            end
            ST_HIZ: ;
            ST_LENT, ST_WAIT: back_n = 1'b0;
            ST_RECL: begin
                ctl_oe = 1'b1; sd_oe = 1'b1; back_n = 1'b0;
            end
            ST_BACKH: begin
                ctl_oe = 1'b1; sd_oe = 1'b1;
            end
            default: ;
        endcase
    end

    AST_BACK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(back_n) |-> !$past(rise)); // R4
    AST_AD_BEFORE_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(back_n) |-> !$past(ad_oe)); // R3
    AST_BACK_AFTER_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(back_n) |-> ctl_oe && !ad_oe); // R6
    AST_AD_AFTER_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ad_oe) |-> back_n && $past(back_n)); // R7
    AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant) |-> !$past(busy) && !$past(rfsh)); // R8
    AST_AD_OFF_LENT: assert property (@(posedge clk) disable iff (!rst_n)
        !back_n |-> !ad_oe); // R11
    AST_CTL_IDLE_LENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!back_n && ctl_oe) |-> ctl_idle); // R11
endmodule

// File: rtl/xbr_park.sv
// SDRAM pin holder: passes the live pin values while the bus is owned and
// replays the last owned values while it is lent out.
// Assumes owned is high only in the owned state of the sequencer.
module xbr_park #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         owned,
    input  logic [W-1:0] sd_in,
    output logic [W-1:0] sd_out
);
    logic [W-1:0] hold_q;

    // Capture the live values on every owned edge.
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_q <= '0;
        else if (owned) hold_q <= sd_in;
    end

    assign sd_out = owned ? sd_in : hold_q;

    AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!owned && !$past(owned)) |-> $stable(sd_out)); // R10
endmodule

// File: rtl/xbus_release.sv
// External bus release arbiter top: phase/sampler, sequencer, SDRAM holder
// and refresh-request line. clk runs at twice the bus clock.
module xbus_release #(
    parameter int SD_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            breq_n_i,
    input  logic            busy_i,
    input  logic            rfsh_req_i,
    input  logic            park_en_i,
    input  logic [SD_W-1:0] sd_in_i,
    output logic            bus_ck_o,
    output logic            grant_o,
    output logic            ad_oe_o,
    output logic            ctl_oe_o,
    output logic            ctl_idle_o,
    output logic            sd_oe_o,
    output logic [SD_W-1:0] sd_out_o,
    output logic            back_n_o,
    output logic            rfsh_n_o
);
    logic rise, req;

    xbr_phase u_phase (
        .clk(clk), .rst_n(rst_n), .breq_n(breq_n_i),
        .rise_o(rise), .bus_ck_o(bus_ck_o), .req_o(req)
    );

    xbr_seq u_seq (
        .clk(clk), .rst_n(rst_n), .rise(rise), .req(req),
        .busy(busy_i), .rfsh(rfsh_req_i), .park(park_en_i),
        .grant(grant_o), .ad_oe(ad_oe_o), .ctl_oe(ctl_oe_o),
        .ctl_idle(ctl_idle_o), .sd_oe(sd_oe_o), .back_n(back_n_o)
    );

    xbr_park #(.W(SD_W)) u_park (
        .clk(clk), .rst_n(rst_n), .owned(grant_o),
        .sd_in(sd_in_i), .sd_out(sd_out_o)
    );

    // Ask for the bus back while a refresh waits and the bus is lent.
    assign rfsh_n_o = ~(rfsh_req_i & ~back_n_o);

    AST_RFSH_ONLY_LENT: assert property (@(posedge clk) disable iff (!rst_n)
        !rfsh_n_o |-> !back_n_o); // R9
endmodule

// File: tb/tb_xbus_release.sv
// Bench: behavioural timeline model (event offsets in half cycles) compared
// with every output after every clk edge.
module tb_xbus_release;
    localparam int W = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, breq_n = 1'b1, busy = 1'b0, rfsh = 1'b0, park = 1'b0;
    logic [W-1:0] sd_in = '0;
    logic bus_ck, grant, ad_oe, ctl_oe, ctl_idle, sd_oe, back_n, rfsh_n;
    logic [W-1:0] sd_out;

    xbus_release #(.SD_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .breq_n_i(breq_n), .busy_i(busy),
        .rfsh_req_i(rfsh), .park_en_i(park), .sd_in_i(sd_in),
        .bus_ck_o(bus_ck), .grant_o(grant), .ad_oe_o(ad_oe),
        .ctl_oe_o(ctl_oe), .ctl_idle_o(ctl_idle), .sd_oe_o(sd_oe),
        .sd_out_o(sd_out), .back_n_o(back_n), .rfsh_n_o(rfsh_n)
    );

    int total = 0, bad = 0;
    bit done = 1'b0;

    // Model: mode 0 owned, 1 releasing, 2 lent, 3 reclaiming; t0 = start edge.
    int k = 0, mode = 0, t0 = 0;
    bit bs = 1'b0;
    logic [W-1:0] hold = '0;
    bit e_ck, e_g, e_ad, e_c, e_idle, e_sd, e_back;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s edge=%0d act=%0d exp=%0d", req, what, k, act, exp);
        end
    endtask

    // Advance the model by one clk edge using the inputs present at it.
    task automatic model_edge();
        int d;
        if (mode == 0) hold = sd_in;
        case (mode)
            0: if (k % 2 == 0 && bs && !busy && !rfsh) begin mode = 1; t0 = k; end
            1: if (k == t0 + 3) mode = 2;
            2: if (k % 2 == 0 && !bs) begin mode = 3; t0 = k; end
            3: if (k == t0 + 4) mode = 0;
            default: ;
        endcase
        if (k % 2 == 1) bs = !breq_n;   // falling bus edge sample (R1)
        d = k - t0;
        e_ck = (k % 2 == 0);
        e_g = 0; e_ad = 0; e_c = 0; e_idle = 1; e_sd = park; e_back = 1;
        case (mode)
            0: begin e_g = 1; e_ad = 1; e_c = 1; e_idle = 0; e_sd = 1; end
            1: if (d < 2) begin e_ad = 1; e_c = 1; e_sd = 1; end
            2: e_back = 0;
            3: begin
                if (d < 2) e_back = 0;
                else begin e_c = 1; e_sd = 1; e_back = (d == 3); end
            end
            default: ;
        endcase
        k++;
    endtask

    task automatic step();
        logic [W-1:0] e_out;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        e_out = (mode == 0) ? sd_in : hold;
        chk(bus_ck == e_ck, "R1", "bus_ck", bus_ck, e_ck);
        chk(grant == e_g, "R2 R7 R8", "grant", grant, e_g);
        chk(ad_oe == e_ad, "R3 R7", "ad_oe", ad_oe, e_ad);
        chk(ctl_oe == e_c, "R3 R5", "ctl_oe", ctl_oe, e_c);
        chk(ctl_idle == e_idle, "R2 R7", "ctl_idle", ctl_idle, e_idle);
        chk(back_n == e_back, "R4 R6", "back_n", back_n, e_back);
        chk(sd_oe == e_sd, "R3 R10", "sd_oe", sd_oe, e_sd);
        chk(sd_out == e_out, "R10", "sd_out", sd_out, e_out);
        chk(rfsh_n == !(rfsh && !e_back), "R9", "rfsh_n", rfsh_n, !(rfsh && !e_back));
        chk(!(ad_oe && !back_n), "R11", "ad_oe while lent", ad_oe, 0);
        chk(!(ctl_oe && !back_n && !ctl_idle), "R11", "active strobes while lent", ctl_oe, 0);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        sd_in = 5'd5;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        chk(grant && ad_oe && ctl_oe && sd_oe, "R12", "enables", {grant, ad_oe, ctl_oe, sd_oe}, 15);
        chk(back_n == 1 && ctl_idle == 0 && bus_ck == 0, "R12", "ack/idle/ck",
            {back_n, ctl_idle, bus_ck}, 4);
        rst_n = 1'b1;
        run(4);
        // Basic release and reclaim, no parking
        breq_n = 0; run(10); breq_n = 1; run(12);
        // R8: busy blocks the grant
        busy = 1; breq_n = 0; run(8); busy = 0; run(8); breq_n = 1; run(10);
        // R8 / R9: refresh blocks grant, then asks for the bus back
        rfsh = 1; breq_n = 0; run(8); rfsh = 0; run(10);
        rfsh = 1; run(6); breq_n = 1; run(10); rfsh = 0; run(4);
        // R10: parked SDRAM pins hold while live values change
        park = 1; sd_in = 5'd9; breq_n = 0; run(10);
        sd_in = 5'd3; run(6); sd_in = 5'd22; breq_n = 1; run(10); park = 0;
        // R5 R6 R7: withdrawal at different phases
        for (int i = 0; i < 6; i++) begin
            breq_n = 0; run(6 + i); breq_n = 1; run(5 + (i % 3));
        end
        run(10);
        // R1: low pulse spanning only a rising bus edge is ignored
        if (k % 2 == 1) run(1);
        breq_n = 0; run(1); breq_n = 1; run(6);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule